// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Coherent Byte Buffering

This block is a 16-bit up/down timer that produces center-aligned pulse-width modulation on one or more channels. When running, the counter climbs from zero to a programmed turnaround value and then falls back toward zero. Each channel compares its own 16-bit threshold against the count. In PWM mode, matches on the rising and falling halves of the count set and clear the channel pin. This places every pulse symmetrically about the low point of the count.

Software reaches the block through an 8-bit write port and a combinational read port. Every 16-bit quantity is therefore written as two bytes. The bytes land in a shadow buffer and are copied into the active register as one unit, so the counter never sees half of an old value and half of a new one. For the turnaround value, and for channels in PWM mode, the copy waits for the turnaround point while the timer runs. A channel in compare mode copies as soon as both bytes are present. Writing a control register throws away any half-written value that belongs to it.

The counter state machine has three named states. `CNT_IDLE` is held after reset until the run bit is first seen. `CNT_UP` increments the count, and `CNT_DOWN` decrements it. The named transitions are:
- start: `CNT_IDLE` to `CNT_UP`, when run is 1.
- turn: `CNT_UP` to `CNT_DOWN`, at the turnaround value when that value is 2 or more.
- bounce: `CNT_UP` to `CNT_UP`, when the turnaround value is 0 (the count wraps) or 1.
- floor: `CNT_DOWN` to `CNT_UP`, when the count steps from 1 to 0.
- restart: any running state to `CNT_UP`, when a counter byte is written.

Top module: `cpwm_timer`

## Requirements
- R1: Register map and reset state.
  - Register addresses: timer control 0x00; turnaround value high byte 0x01 and low byte 0x02; count high byte 0x03 and low byte 0x04.
  - Channel n occupies a 4-byte block starting at 0x08+4n: control at +0, threshold high byte at +1, threshold low byte at +2.
  - Reads of the turnaround and threshold addresses return the active value.
  - After reset, every register reads 0, every pin and interrupt is low, and the count stays at 0 until the run bit (timer control bit 0) is set.
- R2: Counting, freezing and restart.
  - With run=1 and a turnaround value M of 2 or more, the count goes 0,1,…,M,M-1,…,1 and then repeats, giving a period of 2M cycles.
  - With M=1 the count alternates 0,1.
  - With run=0 the count holds its value.
  - A write to either count byte sets the count to 0, counting upward.
- R3: With a turnaround value of 0, the counter runs upward through 0xFFFF and wraps to 0. The wrap point is treated as the turnaround.
- R4: A channel with control bit 0 = 1 (PWM mode) and bit 1 = 0 (normal polarity), and threshold V with 0<V<M, drives its pin high for exactly 2V cycles of every 2M-cycle period. A match while counting up drives the pin low; a match while counting down drives it high.
- R5: With channel control bit 1 = 1 (inverted polarity), the matches act the other way round, and the pin is high for 2M-2V cycles of each period.
- R6: A write to a value byte goes only to its buffer. The buffered pair becomes active only once both bytes have been written, in either order. While running, the turnaround value and the thresholds of PWM-mode channels are copied only at the turnaround.
- R7: A channel in compare mode (control bit 0 = 0) copies its threshold on the cycle after the second byte is written, even while running. While run=0, every complete pair is copied on the cycle after its second byte.
- R8: A write to timer control discards a half-written turnaround value. A write to a channel control register discards that channel's half-written threshold.
- R9: The overflow flag (timer control bit 7) is set at each turnaround and is cleared by writing 1 to bit 7. `ovf_irq` equals the flag ANDed with the overflow enable (timer control bit 1).
- R10: A channel's flag (control bit 7) is set on every count equal to its threshold and is cleared by writing 1 to bit 7. Its `ch_irq` bit equals the flag ANDed with the channel enable (control bit 2).
- R11: In compare mode the channel pin toggles on each match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | BW | Byte write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | BW | Read data, combinational |
| pwm_out | output | NUM_CH | Channel pins |
| ovf_irq | output | 1 | Overflow interrupt |
| ch_irq | output | NUM_CH | Channel interrupts |

## Verification
The bench goes after several corner cases; for each, a faulty design shows a specific symptom:
- One byte of a pair written and then read back: a design that copies on any single byte would show a torn value.
- A pair completed mid-period and read before and after the next turnaround: a design that copies early shows the new value too soon.
- A control write between the two bytes: a design that skips the cancel would commit a mix of old and new bytes.
- Inverted polarity: with the direction test reversed, the measured pulse width would come out as 2V instead of 2M-2V.
- Turnaround values of 1 and of 0: a counter that mishandles its floor state would run away past its limit or never wrap.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_state_e;

    // timer control bits
    localparam int TCTL_RUN_BIT  = 0;
    localparam int TCTL_IE_BIT   = 1;
    localparam int TCTL_FLAG_BIT = 7;

    // channel control bits
    localparam int CCTL_PWM_BIT  = 0;
    localparam int CCTL_POL_BIT  = 1;
    localparam int CCTL_IE_BIT   = 2;
    localparam int CCTL_FLAG_BIT = 7;

    // byte addresses
    localparam int OFS_TCTL   = 0;
    localparam int OFS_MOD_HI = 1;
    localparam int OFS_MOD_LO = 2;
    localparam int OFS_CNT_HI = 3;
    localparam int OFS_CNT_LO = 4;
    localparam int CH_BASE    = 8;
    localparam int CH_STRIDE  = 4;
    localparam int CH_OFS_CTL = 0;
    localparam int CH_OFS_HI  = 1;
    localparam int CH_OFS_LO  = 2;

endpackage

// File: rtl/cpwm_regpair.sv
module cpwm_regpair #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [BW-1:0]   wr_byte,
    input  logic            cancel,
    input  logic            load_ok,
    output logic [2*BW-1:0] act_q
);
    logic [BW-1:0] buf_hi_q, buf_lo_q;
    logic          hi_q, lo_q;
    logic          load;

    assign load = hi_q && lo_q && load_ok && !cancel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_hi_q <= '0;
            buf_lo_q <= '0;
            hi_q     <= 1'b0;
            lo_q     <= 1'b0;
            act_q    <= '0;
        end else begin
            if (wr_hi) buf_hi_q <= wr_byte;
            if (wr_lo) buf_lo_q <= wr_byte;
            if (cancel) begin
                hi_q <= 1'b0;
                lo_q <= 1'b0;
            end else begin
                hi_q <= (hi_q && !load) || wr_hi;
                lo_q <= (lo_q && !load) || wr_lo;
            end
            if (load) act_q <= {buf_hi_q, buf_lo_q};
        end
    end

    // R6: an incomplete pair never changes the active value
    a_r6_hold_partial: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q) |=> $stable(act_q));

    // R8: a control write leaves no byte pending
    a_r8_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!hi_q && !lo_q));

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [CW-1:0] mod_act,
    output logic [CW-1:0] cnt_q,
    output logic          tick,
    output logic          turn,
    output logic          down
);
    cnt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] turn_val;

    assign turn_val = (mod_act == '0) ? {CW{1'b1}} : mod_act;
    assign tick     = run && (state_q != CNT_IDLE);
    assign turn     = tick && (state_q == CNT_UP) && (cnt_q == turn_val);
    assign down     = (state_q == CNT_DOWN);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d   = '0;
            state_d = (state_q == CNT_IDLE) ? CNT_IDLE : CNT_UP;
        end else begin
            unique case (state_q)
                CNT_IDLE: begin
                    if (run) state_d = CNT_UP;
                end
                CNT_UP: begin
                    if (run) begin
                        if (turn) begin
                            if (mod_act <= CW'(1)) begin
                                cnt_d = '0;
                            end else begin
                                cnt_d   = cnt_q - CW'(1);
                                state_d = CNT_DOWN;
                            end
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                CNT_DOWN: begin
                    if (run) begin
                        cnt_d = cnt_q - CW'(1);
                        if (cnt_q == CW'(1)) state_d = CNT_UP;
                    end
                end
                default: state_d = CNT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R2: a running count moves by one step or lands on zero
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> ((cnt_q == $past(cnt_q) + CW'(1)) ||
                            (cnt_q == $past(cnt_q) - CW'(1)) ||
                            (cnt_q == '0)));

    // R2: a stopped count holds
    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));

    // R2: turnaround above one reverses direction
    a_r2_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
        (turn && !clr && mod_act > CW'(1)) |=> (state_q == CNT_DOWN));

    // R3: zero turnaround wraps to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (turn && !clr && mod_act == '0) |=> (cnt_q == '0 && state_q == CNT_UP));

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            val_hi_wr,
    input  logic            val_lo_wr,
    input  logic [BW-1:0]   wr_byte,
    input  logic            run,
    input  logic            tick,
    input  logic            turn,
    input  logic            down,
    input  logic [2*BW-1:0] cnt,
    output logic [BW-1:0]   ctl_rd,
    output logic [2*BW-1:0] val_act,
    output logic            pwm,
    output logic            irq
);
    logic pwm_mode_q, pol_q, ie_q, flag_q, pwm_q;
    logic match, load_ok;

    assign load_ok = !run || !pwm_mode_q || turn;
    assign match   = tick && (cnt == val_act);

    cpwm_regpair #(.BW(BW)) u_val (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (val_hi_wr),
        .wr_lo   (val_lo_wr),
        .wr_byte (wr_byte),
        .cancel  (ctl_wr),
        .load_ok (load_ok),
        .act_q   (val_act)
    );

    // control and flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_mode_q <= 1'b0;
            pol_q      <= 1'b0;
            ie_q       <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            if (ctl_wr) begin
                pwm_mode_q <= wr_byte[CCTL_PWM_BIT];
                pol_q      <= wr_byte[CCTL_POL_BIT];
                ie_q       <= wr_byte[CCTL_IE_BIT];
            end
            if (match)
                flag_q <= 1'b1;
            else if (ctl_wr && wr_byte[CCTL_FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    // pin output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else if (match) begin
            if (pwm_mode_q) pwm_q <= down ? !pol_q : pol_q;
            else            pwm_q <= !pwm_q;
        end
    end

    always_comb begin
        ctl_rd                = '0;
        ctl_rd[CCTL_PWM_BIT]  = pwm_mode_q;
        ctl_rd[CCTL_POL_BIT]  = pol_q;
        ctl_rd[CCTL_IE_BIT]   = ie_q;
        ctl_rd[CCTL_FLAG_BIT] = flag_q;
    end

    assign pwm = pwm_q;
    assign irq = flag_q && ie_q;

    // R10: every match leaves the flag set
    a_r10_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    // R4: the pin only moves on a match
    a_r4_pin_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pwm_q));

    // R4: normal polarity, rising-half match drives low
    a_r4_up_low: assert property (@(posedge clk) disable iff (!rst_n)
        (match && pwm_mode_q && !down && !pol_q && !ctl_wr) |=> !pwm_q);

    // R5: inverted polarity, falling-half match drives low
    a_r5_down_low: assert property (@(posedge clk) disable iff (!rst_n)
        (match && pwm_mode_q && down && pol_q && !ctl_wr) |=> !pwm_q);

    // R11: compare mode toggles the pin
    a_r11_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !pwm_mode_q && !ctl_wr) |=> (pwm_q != $past(pwm_q)));

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int BW     = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BW-1:0]     rd_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              ovf_irq,
    output logic [NUM_CH-1:0] ch_irq
);
    localparam int CW = 2 * BW;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic          run_q, ie_q, ovf_q;
    logic          tctl_wr, cnt_clr;
    logic [CW-1:0] mod_act, cnt;
    logic          tick, turn, down;

    logic [BW-1:0] ch_ctl [NUM_CH];
    logic [CW-1:0] ch_val [NUM_CH];

    assign tctl_wr = wr_en && at(wr_addr, OFS_TCTL);
    assign cnt_clr = wr_en && (at(wr_addr, OFS_CNT_HI) || at(wr_addr, OFS_CNT_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (tctl_wr) begin
                run_q <= wr_data[TCTL_RUN_BIT];
                ie_q  <= wr_data[TCTL_IE_BIT];
            end
            if (turn)
                ovf_q <= 1'b1;
            else if (tctl_wr && wr_data[TCTL_FLAG_BIT])
                ovf_q <= 1'b0;
        end
    end

    cpwm_regpair #(.BW(BW)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_en && at(wr_addr, OFS_MOD_HI)),
        .wr_lo   (wr_en && at(wr_addr, OFS_MOD_LO)),
        .wr_byte (wr_data),
        .cancel  (tctl_wr),
        .load_ok (!run_q || turn),
        .act_q   (mod_act)
    );

    cpwm_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .clr     (cnt_clr),
        .mod_act (mod_act),
        .cnt_q   (cnt),
        .tick    (tick),
        .turn    (turn),
        .down    (down)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * g;
        cpwm_channel #(.BW(BW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (wr_en && at(wr_addr, BASE + CH_OFS_CTL)),
            .val_hi_wr (wr_en && at(wr_addr, BASE + CH_OFS_HI)),
            .val_lo_wr (wr_en && at(wr_addr, BASE + CH_OFS_LO)),
            .wr_byte   (wr_data),
            .run       (run_q),
            .tick      (tick),
            .turn      (turn),
            .down      (down),
            .cnt       (cnt),
            .ctl_rd    (ch_ctl[g]),
            .val_act   (ch_val[g]),
            .pwm       (pwm_out[g]),
            .irq       (ch_irq[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (at(rd_addr, OFS_TCTL)) begin
            rd_data[TCTL_RUN_BIT]  = run_q;
            rd_data[TCTL_IE_BIT]   = ie_q;
            rd_data[TCTL_FLAG_BIT] = ovf_q;
        end else if (at(rd_addr, OFS_MOD_HI)) begin
            rd_data = mod_act[CW-1:BW];
        end else if (at(rd_addr, OFS_MOD_LO)) begin
            rd_data = mod_act[BW-1:0];
        end else if (at(rd_addr, OFS_CNT_HI)) begin
            rd_data = cnt[CW-1:BW];
        end else if (at(rd_addr, OFS_CNT_LO)) begin
            rd_data = cnt[BW-1:0];
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (at(rd_addr, CH_BASE + CH_STRIDE * i + CH_OFS_CTL)) rd_data = ch_ctl[i];
            if (at(rd_addr, CH_BASE + CH_STRIDE * i + CH_OFS_HI))  rd_data = ch_val[i][CW-1:BW];
            if (at(rd_addr, CH_BASE + CH_STRIDE * i + CH_OFS_LO))  rd_data = ch_val[i][BW-1:0];
        end
    end

    assign ovf_irq = ovf_q && ie_q;

    // R9: every turnaround leaves the overflow flag set
    a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        turn |=> ovf_q);

    // R6: while running the turnaround value changes only at a turnaround
    a_r6_mod_at_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !turn) |=> $stable(mod_act));

endmodule

// File: tb/cpwm_timer_tb_top.sv
module cpwm_timer_tb_top;
    localparam int NUM_CH = 2;
    localparam int BW     = 8;
    localparam int ADDR_W = 5;

    localparam int N_VEC = 6;
    localparam int VEC_MOD [N_VEC] = '{10, 20, 7, 50, 4, 12};
    localparam int VEC_VAL [N_VEC] = '{3, 1, 6, 25, 2, 4};
    localparam int VEC_POL [N_VEC] = '{0, 0, 0, 0, 0, 1};

    localparam logic [4:0] A_TCTL = 5'h00, A_MHI = 5'h01, A_MLO = 5'h02,
                           A_CHI = 5'h03, A_CLO = 5'h04,
                           A_C0CTL = 5'h08, A_C0HI = 5'h09, A_C0LO = 5'h0A;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [BW-1:0]     wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [BW-1:0]     rd_data;
    logic [NUM_CH-1:0] pwm_out;
    logic              ovf_irq;
    logic [NUM_CH-1:0] ch_irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    cpwm_timer #(.NUM_CH(NUM_CH), .BW(BW), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .ovf_irq(ovf_irq), .ch_irq(ch_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd16(input logic [4:0] hi, output int v);
        logic [7:0] h, l;
        rd(hi, h);
        #0 rd_addr = hi + 5'd1;
        #0.5 l = rd_data;
        v = {h, l};
    endtask

    task automatic poll_bit(input logic [4:0] a, input int b, output bit ok);
        logic [7:0] d;
        ok = 1'b0;
        for (int k = 0; k < 2000 && !ok; k++) begin
            rd(a, d);
            if (d[b]) ok = 1'b1;
        end
    endtask

    task automatic setup(input int m, input int v, input logic [7:0] cctl);
        wr(A_TCTL, 8'h00);
        wr(A_CLO, 8'h00);
        wr(A_MHI, 8'(m >> 8));
        wr(A_MLO, 8'(m));
        wr(A_C0CTL, cctl);
        wr(A_C0HI, 8'(v >> 8));
        wr(A_C0LO, 8'(v));
        wr(A_TCTL, 8'h01);
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int k = 0; k < 1000 && pwm_out[0] !== 1'b0; k++) @(negedge clk);
        for (int k = 0; k < 1000 && pwm_out[0] !== 1'b1; k++) @(negedge clk);
        while (pwm_out[0] === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
        while (pwm_out[0] === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int v, hi, lo, exp_hi, o1, prev;
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_TCTL, d);  chk(d == 8'h00, "R1 tctl", d, 0);
        rd16(A_MHI, v); chk(v == 0, "R1 mod", v, 0);
        rd16(A_CHI, v); chk(v == 0, "R1 cnt", v, 0);
        rd(A_C0CTL, d); chk(d == 8'h00, "R1 cctl", d, 0);
        rd16(A_C0HI, v); chk(v == 0, "R1 val", v, 0);
        chk(pwm_out == '0 && ovf_irq == 1'b0 && ch_irq == '0, "R1 pins", int'(pwm_out), 0);
        repeat (20) @(negedge clk);
        rd16(A_CHI, v); chk(v == 0, "R1 held until run", v, 0);

        // R6 while stopped: lone low byte not committed; R7 pair commits at once
        wr(A_MLO, 8'd9);
        rd16(A_MHI, v); chk(v == 0, "R6 lone byte", v, 0);
        wr(A_MHI, 8'd0);
        rd16(A_MHI, v); chk(v == 9, "R7 stopped load", v, 9);

        // vector table: R2 period, R4 and R5 width
        for (int i = 0; i < N_VEC; i++) begin
            setup(VEC_MOD[i], VEC_VAL[i], 8'(1 | (VEC_POL[i] << 1)));
            measure(hi, lo);
            exp_hi = VEC_POL[i] ? 2 * VEC_MOD[i] - 2 * VEC_VAL[i] : 2 * VEC_VAL[i];
            chk(hi == exp_hi, VEC_POL[i] ? "R5 inverted width" : "R4 width", hi, exp_hi);
            chk(hi + lo == 2 * VEC_MOD[i], "R2 period", hi + lo, 2 * VEC_MOD[i]);
        end

        // R6 boundary copy while running
        setup(10, 3, 8'h01);
        wr(A_TCTL, 8'h81);
        poll_bit(A_TCTL, 7, ok); chk(ok, "R9 flag at turnaround", ok, 1);
        wr(A_MLO, 8'd6);
        wr(A_MHI, 8'd0);
        rd16(A_MHI, v); chk(v == 10, "R6 wait for turnaround", v, 10);
        repeat (25) @(negedge clk);
        rd16(A_MHI, v); chk(v == 6, "R6 copied at turnaround", v, 6);

        // R8 cancel of turnaround value, R6 low-then-high order
        wr(A_MHI, 8'd0);
        wr(A_TCTL, 8'h01);
        wr(A_MLO, 8'd8);
        repeat (30) @(negedge clk);
        rd16(A_MHI, v); chk(v == 6, "R8 mod cancel", v, 6);
        wr(A_MHI, 8'd0);
        repeat (30) @(negedge clk);
        rd16(A_MHI, v); chk(v == 8, "R6 either order", v, 8);

        // R8 channel cancel
        wr(A_C0HI, 8'd0);
        wr(A_C0CTL, 8'h01);
        wr(A_C0LO, 8'd2);
        repeat (40) @(negedge clk);
        rd16(A_C0HI, v); chk(v == 3, "R8 channel cancel", v, 3);

        // R7 compare mode immediate copy, R10 flag and irq, R11 toggle
        wr(A_C0CTL, 8'h84);
        wr(A_C0HI, 8'd0);
        wr(A_C0LO, 8'd5);
        rd16(A_C0HI, v); chk(v == 5, "R7 compare immediate", v, 5);
        wr(A_C0CTL, 8'h84);
        poll_bit(A_C0CTL, 7, ok); chk(ok, "R10 flag on match", ok, 1);
        chk(ch_irq[0] == 1'b1, "R10 irq", int'(ch_irq[0]), 1);
        o1 = int'(pwm_out[0]);
        wr(A_C0CTL, 8'h84);
        rd(A_C0CTL, d); chk(d[7] == 1'b0, "R10 w1c", int'(d[7]), 0);
        chk(ch_irq[0] == 1'b0, "R10 irq cleared", int'(ch_irq[0]), 0);
        poll_bit(A_C0CTL, 7, ok);
        chk(int'(pwm_out[0]) == 1 - o1, "R11 toggle", int'(pwm_out[0]), 1 - o1);

        // R9 overflow interrupt gating and clear
        wr(A_TCTL, 8'h83);
        poll_bit(A_TCTL, 7, ok);
        chk(ovf_irq == 1'b1, "R9 irq", int'(ovf_irq), 1);
        wr(A_TCTL, 8'h01);
        rd(A_TCTL, d);
        chk(ovf_irq == 1'b0 && d[7], "R9 enable gates irq", int'(ovf_irq), 0);
        wr(A_TCTL, 8'h81);
        rd(A_TCTL, d); chk(d[7] == 1'b0, "R9 w1c", int'(d[7]), 0);

        // R2 freeze
        wr(A_TCTL, 8'h00);
        rd16(A_CHI, v);
        repeat (10) @(negedge clk);
        rd16(A_CHI, hi); chk(hi == v, "R2 freeze", hi, v);

        // R2 turnaround of one
        setup(1, 0, 8'h01);
        repeat (5) @(negedge clk);
        rd16(A_CHI, prev);
        for (int k = 0; k < 4; k++) begin
            rd(A_CLO, d);
            chk(int'(d) <= 1 && int'(d) != prev, "R2 mod one alternates", int'(d), 1 - prev);
            prev = int'(d);
        end

        // R3 zero turnaround wraps
        setup(0, 0, 8'h01);
        wr(A_TCTL, 8'h81);
        repeat (300) @(negedge clk);
        rd16(A_CHI, v); chk(v > 250 && v < 350, "R3 counts past zero limit", v, 300);
        rd(A_TCTL, d); chk(d[7] == 1'b0, "R3 no early turnaround", int'(d[7]), 0);
        repeat (65400) @(negedge clk);
        rd(A_TCTL, d); chk(d[7] == 1'b1, "R3 wrap sets flag", int'(d[7]), 1);
        rd16(A_CHI, v); chk(v < 400, "R3 wrapped count", v, 200);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule